// File: doc/BRIEF.md
# Sequential Sign-Magnitude Shift-Add Multiplier

This block forms the product of two signed 8-bit numbers over several clock cycles with one adder and two shifting registers, not a full array multiplier. Operand A arrives in sign-magnitude form: a sign bit above a 7-bit magnitude. Operand B arrives in two's complement form and is converted to sign-magnitude at the input. The magnitudes go through a shift-add loop. The product sign is the exclusive-or of the operand signs and is carried around the loop, not through it.

A caller pulses `start` while the block is idle. It then waits for `busy` to fall, which happens a fixed eight cycles later. At that point the 15-bit product is available in two forms: sign-magnitude, and two's complement. The two's complement form comes from a combinational converter. That converter maps a negative sign with a zero magnitude to plain zero. The product holds its value until the next accepted start.

Top module: `sm_shift_mult`

## Requirements
- R1: While reset is asserted and after it is released, `busy` is 0 and both `prodSm` and `prodTc` are 0.
- R2: A `start` sampled high while `busy` is 0 makes `busy` high from the next cycle. It stays high for exactly 8 consecutive cycles (magnitude width plus one).
- R3: Once `busy` falls, `prodSm[13:0]` equals the product of `opASm[6:0]` and the magnitude of operand B.
- R4: Once `busy` falls, `prodSm[14]` equals `opASm[7]` XOR `opBTc[7]`. This holds even when the magnitude is zero, so a minus-zero product can appear in sign-magnitude form.
- R5: `opBTc` is read as two's complement. A negative value uses sign 1 and magnitude equal to the low 7 bits of its negation. The value -128 (0x80) therefore becomes sign 1 with magnitude 0.
- R6: `prodTc` is the 15-bit two's complement of the signed product. When `prodSm[13:0]` is 0, `prodTc` is 0 whatever the sign bit is.
- R7: `start` pulses and operand changes while `busy` is high have no effect on the running product or on the length of the busy window.
- R8: While `busy` is 0 and no `start` is sampled, `prodSm` and `prodTc` keep their values, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply when idle |
| opASm | input | 8 | Operand A, sign-magnitude (bit 7 sign) |
| opBTc | input | 8 | Operand B, two's complement |
| busy | output | 1 | High while the shift-add loop runs |
| prodSm | output | 15 | Product, sign-magnitude (bit 14 sign) |
| prodTc | output | 15 | Product, two's complement |

## Verification
Seeded random operand pairs test the shift-add loop against every mix of sign, bit density and magnitude. A wrong add condition or shift direction shows up as a wrong magnitude, and a wrong sign rule shows up as a wrong sign. Directed pairs target the edges. The full-scale pair 127 by -127 checks the top magnitude bit and a large negative two's complement result. Zero operands with a negative sign separate a correct minus-zero conversion from a plain invert-and-add. B = -128 and B = -1 exercise the input negation at its wrap point and at its smallest magnitude. Start pulses and operand changes during a run, and operand changes while idle, show whether the block restarts or leaks state when it should not.

// File: rtl/smmul_pkg.sv
package smmul_pkg;

  typedef struct packed {
    logic load;  // capture operands, clear accumulator
    logic step;  // one shift-add iteration
  } ctrlStrobes_t;

endpackage

// File: rtl/smmul_tc2sm.sv
module smmul_tc2sm #(
  parameter int W = 8
) (
  input  logic [W-1:0] tcIn,
  output logic [W-1:0] smOut
);
  logic [W-2:0] negLow;

  // low bits of the negation: invert and add one, wrap allowed
  assign negLow = ~tcIn[W-2:0] + (W-1)'(1);

  always_comb begin
    if (tcIn[W-1]) smOut = {1'b1, negLow};
    else           smOut = tcIn;
  end
endmodule

// File: rtl/smmul_sm2tc.sv
module smmul_sm2tc #(
  parameter int W = 15
) (
  input  logic [W-1:0] smIn,
  output logic [W-1:0] tcOut
);
  logic [W-2:0] mag;
  logic         negNonZero;

  assign mag        = smIn[W-2:0];
  // minus zero is folded to plain zero here
  assign negNonZero = smIn[W-1] && (mag != '0);

  always_comb begin
    if (negNonZero) tcOut = ~{1'b0, mag} + W'(1);
    else            tcOut = {1'b0, mag};
  end
endmodule

// File: rtl/smmul_ctrl.sv
module smmul_ctrl
  import smmul_pkg::*;
#(
  parameter int CYCLES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output logic         busy,
  output ctrlStrobes_t strb
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t state;
  logic [CNT_W-1:0] iterCnt;
  logic lastIter;

  assign lastIter  = (iterCnt == CNT_W'(CYCLES - 1));
  assign busy      = (state == ST_RUN);
  assign strb.load = (state == ST_IDLE) && start;
  assign strb.step = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          if (lastIter) state <= ST_IDLE;
          else          iterCnt <= iterCnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smmul_datapath.sv
module smmul_datapath
  import smmul_pkg::*;
#(
  parameter int MAG_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic               signA,
  input  logic [MAG_W-1:0]   magA,
  input  logic               signB,
  input  logic [MAG_W-1:0]   magB,
  output logic               prodSign,
  output logic [2*MAG_W-1:0] prodMag
);
  localparam int REG_W = 2 * MAG_W;

  logic [REG_W-1:0] shiftUp;    // multiplicand, moves left
  logic [REG_W-1:0] shiftDown;  // multiplier, moves right
  logic [REG_W-1:0] accum;
  logic             signReg;
  logic [REG_W-1:0] addend;

  assign addend   = shiftDown[0] ? shiftUp : '0;
  assign prodMag  = accum;
  assign prodSign = signReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftUp   <= '0;
      shiftDown <= '0;
      accum     <= '0;
      signReg   <= 1'b0;
    end else if (strb.load) begin
      shiftUp   <= {{MAG_W{1'b0}}, magA};
      shiftDown <= {{MAG_W{1'b0}}, magB};
      accum     <= '0;
      signReg   <= signA ^ signB;
    end else if (strb.step) begin
      accum     <= accum + addend;
      shiftUp   <= shiftUp << 1;
      shiftDown <= shiftDown >> 1;
    end
  end
endmodule

// File: rtl/sm_shift_mult.sv
module sm_shift_mult
  import smmul_pkg::*;
#(
  parameter int MAG_W = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [MAG_W:0]       opASm,
  input  logic [MAG_W:0]       opBTc,
  output logic                 busy,
  output logic [2*MAG_W:0]     prodSm,
  output logic [2*MAG_W:0]     prodTc
);
  localparam int OP_W   = MAG_W + 1;
  localparam int PROD_W = 2 * MAG_W + 1;
  localparam int CYCLES = MAG_W + 1;

  ctrlStrobes_t strb;
  logic [OP_W-1:0]   opBSm;
  logic              prodSign;
  logic [PROD_W-2:0] prodMag;

  smmul_tc2sm #(.W(OP_W)) u_inConv (
    .tcIn  (opBTc),
    .smOut (opBSm)
  );

  smmul_ctrl #(.CYCLES(CYCLES)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .busy  (busy),
    .strb  (strb)
  );

  smmul_datapath #(.MAG_W(MAG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .signA    (opASm[OP_W-1]),
    .magA     (opASm[MAG_W-1:0]),
    .signB    (opBSm[OP_W-1]),
    .magB     (opBSm[MAG_W-1:0]),
    .prodSign (prodSign),
    .prodMag  (prodMag)
  );

  assign prodSm = {prodSign, prodMag};

  smmul_sm2tc #(.W(PROD_W)) u_outConv (
    .smIn  (prodSm),
    .tcOut (prodTc)
  );
endmodule

// File: rtl/smmul_checker.sv
module smmul_checker #(
  parameter int MAG_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             signA,
  input logic             signB,
  input logic             busy,
  input logic [2*MAG_W:0] prodSm,
  input logic [2*MAG_W:0] prodTc
);
  localparam int CYCLES = MAG_W + 1;
  localparam int LEN_W  = $clog2(CYCLES + 1) + 1;

  logic [LEN_W-1:0] runLen;
  logic             expSign;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen  <= '0;
      expSign <= 1'b0;
    end else begin
      runLen <= busy ? runLen + LEN_W'(1) : '0;
      if (start && !busy) expSign <= signA ^ signB;
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) !rstN |-> !busy && prodSm == '0);

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> runLen == LEN_W'(CYCLES));

  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> runLen < LEN_W'(CYCLES));

  p_sign_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> prodSm[2*MAG_W] == expSign);

  p_minus_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (prodSm[2*MAG_W-1:0] == '0) |-> prodTc == '0);

  p_tc_sign_r6: assert property (@(posedge clk) disable iff (!rstN)
    (prodSm[2*MAG_W-1:0] != '0) |-> prodTc[2*MAG_W] == prodSm[2*MAG_W]);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(prodSm) && $stable(prodTc));
endmodule

bind sm_shift_mult smmul_checker #(.MAG_W(MAG_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .signA  (opASm[MAG_W]),
  .signB  (opBTc[MAG_W]),
  .busy   (busy),
  .prodSm (prodSm),
  .prodTc (prodTc)
);

// File: tb/sm_shift_mult_tb.sv
module sm_shift_mult_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opASm = '0;
  logic [7:0]  opBTc = '0;
  logic        busy;
  logic [14:0] prodSm;
  logic [14:0] prodTc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sm_shift_mult u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opASm(opASm), .opBTc(opBTc),
    .busy(busy), .prodSm(prodSm), .prodTc(prodTc)
  );

  function automatic int bMagOf(logic [7:0] b);
    int bi = int'($signed(b));
    int ab = (bi < 0) ? -bi : bi;
    return ab % 128;
  endfunction

  function automatic logic [14:0] expSm(logic [7:0] a, logic [7:0] b);
    int m = int'(a[6:0]) * bMagOf(b);
    return {a[7] ^ b[7], 14'(m)};
  endfunction

  function automatic logic [14:0] expTc(logic [7:0] a, logic [7:0] b);
    int m = int'(a[6:0]) * bMagOf(b);
    int v = (a[7] ^ b[7]) ? -m : m;
    return 15'(v);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // pulse start, optionally disturb the run, count busy cycles
  task automatic runMul(input logic [7:0] a, input logic [7:0] b, input bit disturb);
    int busyCnt = 0;
    logic [14:0] eSm = expSm(a, b);
    logic [14:0] eTc = expTc(a, b);
    @(negedge clk);
    opASm = a; opBTc = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && busyCnt < 40) begin
      busyCnt++;
      if (disturb && busyCnt == 2) begin
        start = 1'b1; opASm = 8'($urandom); opBTc = 8'($urandom);
      end else if (disturb && busyCnt == 3) begin
        start = 1'b0;
      end else if (disturb) begin
        opASm = 8'($urandom); opBTc = 8'($urandom);
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(busyCnt == 8, disturb ? "R7" : "R2", "busy length", busyCnt, 8);
    chk(prodSm[13:0] == eSm[13:0], disturb ? "R7" : "R3", "magnitude", int'(prodSm[13:0]), int'(eSm[13:0]));
    chk(prodSm[14] == eSm[14], "R4", "sign", int'(prodSm[14]), int'(eSm[14]));
    chk(prodTc == eTc, "R6", "twos complement", int'($signed(prodTc)), int'($signed(eTc)));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [14:0] holdSm;
    logic [14:0] holdTc;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk(!busy && prodSm == '0 && prodTc == '0, "R1", "in reset", int'(prodSm), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(prodSm == '0 && prodTc == '0, "R1", "product after reset", int'(prodTc), 0);

    // directed corners
    runMul(8'h00, 8'h00, 0);
    runMul(8'h7F, 8'h7F, 0);           // R3 full scale
    runMul(8'h7F, 8'h81, 0);           // R5 B=-127, product -16129
    runMul(8'h81, 8'hFF, 0);           // R5 B=-1 times -1
    runMul(8'h80, 8'h05, 0);           // R6 minus zero operand A
    runMul(8'h23, 8'h80, 0);           // R5 B=-128 becomes minus zero
    runMul(8'h85, 8'h00, 0);           // R4 sign 1 with zero magnitude
    runMul(8'h55, 8'hAA, 0);

    // R7: start and operand churn during a run
    runMul(8'h6B, 8'hC3, 1);
    runMul(8'h9E, 8'h31, 1);

    // R8: idle with changing operands
    holdSm = prodSm; holdTc = prodTc;
    for (int k = 0; k < 6; k++) begin
      opASm = 8'($urandom); opBTc = 8'($urandom);
      @(negedge clk);
    end
    chk(prodSm == holdSm && prodTc == holdTc, "R8", "idle hold", int'(prodSm), int'(holdSm));
    chk(busy == 1'b0, "R8", "idle busy", int'(busy), 0);

    // random operands
    for (int n = 0; n < 300; n++) begin
      runMul(8'($urandom), 8'($urandom), (n % 17) == 0);
      if ((n % 5) == 0) repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    finishRun();
  end
endmodule